// File: doc/BRIEF.md
# Flash Program/Erase Protection Gate

This block sits in front of a block-organised flash array. It decides whether a program, block erase, whole-array erase or lock-bit change may go ahead. A small command decoder watches bus write cycles and needs a setup write followed by a confirm write before anything is attempted. Once the confirm arrives, the request is judged against several protections:

- a power-down/reset input that disables the device;
- a flag that reports the programming supply below its lockout level;
- one lock bit per block;
- a pin that shields only the two boot blocks (indices 0 and 1).

A permanent lock bit freezes the per-block lock bits once it is set.

Every attempt ends with a one-cycle `done` pulse and a status code that gives the reason for a refusal. When the attempt is allowed, `op_go` goes high together with the operation kind, the target block and the mask of blocks that may be altered. The array itself, the voltage sensing and the pulse timing lie outside this block.

Top module: `flash_wp_gate`

## Requirements
- R1: A bus write is taken only in a clock cycle where `ce_n` and `we_n` are both low. A cycle with either one high leaves the decoder state, the lock bits and every output unchanged.
- R2: After `rst_n` and after any cycle with `pd_n` low, the decoder is in read mode, so a following confirm write on its own does nothing.
- R3: A modifying attempt needs two writes: a setup followed by a confirm. The confirm write's `blk` selects the block. The codes are:
  - program: 0x40 followed by any data byte;
  - block erase: 0x20 then 0xD0;
  - whole-array erase: 0x30 then 0xD0;
  - set lock: 0x60 then 0x01;
  - clear lock: 0x60 then 0xD0;
  - set permanent lock: 0x60 then 0x2F.
  
  `op_kind` encodes 1 program, 2 block erase, 3 whole-array erase, 4 set lock, 5 clear lock, 6 permanent lock.
- R4: A wrong confirm code returns the decoder to read mode, raises no `done` and sets `seq_err`. Writing 0x50 in read mode clears `seq_err`.
- R5: Each write cycle taken while `pd_n` is low raises `done` with status 4. Nothing else changes.
- R6: With `vlow` high, every attempt is refused with status 3.
- R7: A program or block erase of a block whose lock bit is set is refused with status 1. The boot blocks are included.
- R8: With `boot_n` low, a program or erase of block 0 or 1 that is not already refused is refused with status 2. Other blocks are not affected. The priority is 4, then 3, then 1, then 2. Status 0 means allowed.
- R9: With `perm_lock` set, set-lock and clear-lock attempts are refused with status 1 and `lock_bits` does not change. A permanent-lock attempt always gets status 0 unless `vlow` is high.
- R10: A whole-array erase sets `op_mask` to the blocks that have no lock bit and no pin protection. The status is 1 if any lock bit is set, otherwise 2 if `boot_n` is low, otherwise 0. `op_go` is high only if the mask is non-zero.
- R11: `done` is high for exactly the one cycle after the confirm write. `op_go` is high in that same cycle when the attempt is allowed. For program and block erase, `op_mask` is one-hot on the block.
- R12: `rst_n` clears `lock_bits` and `perm_lock`. `pd_n` low leaves them untouched. A lock bit falls only through a clear-lock command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| pd_n | input | 1 | Power-down/reset, active low |
| boot_n | input | 1 | Boot-block protect, active low |
| vlow | input | 1 | Programming supply below lockout level |
| cmd | input | 8 | Command or data byte of a write |
| blk | input | BW | Target block index |
| done | output | 1 | One-cycle attempt-complete pulse |
| status | output | 3 | Result code of the last attempt |
| op_go | output | 1 | Attempt allowed, issue to array |
| op_kind | output | 3 | Kind of the last attempt |
| op_blk | output | BW | Block of the last attempt |
| op_mask | output | NBLK | Blocks the array may alter |
| lock_bits | output | NBLK | Per-block lock bits |
| perm_lock | output | 1 | Permanent lock bit |
| seq_err | output | 1 | Bad-confirm sticky flag |

## Verification
The hardest case to reach is a pending setup that is dropped silently. The stimulus issues an erase setup, holds `pd_n` low for one idle cycle, and then sends a valid confirm; that confirm must produce no `done` at all. A second case needs many commands to set up: a locked boot block under pin protection, which must report the lock rather than the pin. To reach it, the bench first loads a mixed lock pattern through the lock commands. It then sweeps every block against every combination of pin, supply flag and operation kind, and computes each status from the priority rule.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_LOCKED = 3'd1,
    ST_BOOT   = 3'd2,
    ST_SUPPLY = 3'd3,
    ST_RESET  = 3'd4
  } wp_status_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_CHIP  = 3'd3,
    OP_LSET  = 3'd4,
    OP_LCLR  = 3'd5,
    OP_PERM  = 3'd6
  } op_kind_e;

  typedef enum logic [2:0] {
    S_READ  = 3'd0,
    S_PROG  = 3'd1,
    S_ERASE = 3'd2,
    S_CHIP  = 3'd3,
    S_LOCK  = 3'd4
  } dec_state_e;

  localparam logic [7:0] CMD_PROG_SU  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SU = 8'h20;
  localparam logic [7:0] CMD_CHIP_SU  = 8'h30;
  localparam logic [7:0] CMD_LOCK_SU  = 8'h60;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_LSET_CF  = 8'h01;
  localparam logic [7:0] CMD_PERM_CF  = 8'h2F;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;

endpackage

// File: rtl/flash_wp_cmd_fsm.sv
module flash_wp_cmd_fsm
  import flash_wp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic     pd_n,
  input  logic [7:0] cmd,
  output logic     exec,
  output op_kind_e exec_kind,
  output logic     seq_err
);

  dec_state_e state_q, state_d;
  logic       seq_err_q, seq_err_d, seq_en;
  logic       bad_cf, clr_st;

  always_comb begin
    state_d   = state_q;
    exec      = 1'b0;
    exec_kind = OP_NONE;
    bad_cf    = 1'b0;
    clr_st    = 1'b0;
    if (!pd_n) begin
      state_d = S_READ;
    end else if (wr) begin
      case (state_q)
        S_READ: begin
          case (cmd)
            CMD_PROG_SU:  state_d = S_PROG;
            CMD_ERASE_SU: state_d = S_ERASE;
            CMD_CHIP_SU:  state_d = S_CHIP;
            CMD_LOCK_SU:  state_d = S_LOCK;
            CMD_CLR_STAT: clr_st  = 1'b1;
            default:      state_d = S_READ;
          endcase
        end
        S_PROG: begin
          exec      = 1'b1;
          exec_kind = OP_PROG;
          state_d   = S_READ;
        end
        S_ERASE: begin
          state_d = S_READ;
          if (cmd == CMD_CONFIRM) begin
            exec      = 1'b1;
            exec_kind = OP_ERASE;
          end else begin
            bad_cf = 1'b1;
          end
        end
        S_CHIP: begin
          state_d = S_READ;
          if (cmd == CMD_CONFIRM) begin
            exec      = 1'b1;
            exec_kind = OP_CHIP;
          end else begin
            bad_cf = 1'b1;
          end
        end
        S_LOCK: begin
          state_d = S_READ;
          case (cmd)
            CMD_LSET_CF: begin exec = 1'b1; exec_kind = OP_LSET; end
            CMD_CONFIRM: begin exec = 1'b1; exec_kind = OP_LCLR; end
            CMD_PERM_CF: begin exec = 1'b1; exec_kind = OP_PERM; end
            default:     bad_cf = 1'b1;
          endcase
        end
        default: state_d = S_READ;
      endcase
    end
  end

  assign seq_en    = bad_cf | clr_st;
  assign seq_err_d = bad_cf;
  assign seq_err   = seq_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_READ;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_err_q <= 1'b0;
    end else if (seq_en) begin
      seq_err_q <= seq_err_d;
    end
  end

  // R2
  pd_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> state_q == S_READ);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_READ && !wr) |=> state_q == S_READ);

  // R4
  bad_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err_q) |-> state_q == S_READ);

endmodule

// File: rtl/flash_wp_lock_regs.sv
module flash_wp_lock_regs #(
  parameter int NBLK = 16,
  parameter int BW   = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic            perm_en,
  input  logic [BW-1:0]   idx,
  output logic [NBLK-1:0] lock_q,
  output logic            perm_q
);

  logic [NBLK-1:0] lock_d;
  logic            lock_en;

  always_comb begin
    lock_d = lock_q;
    if (set_en) lock_d[idx] = 1'b1;
    if (clr_en) lock_d[idx] = 1'b0;
  end

  assign lock_en = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= 1'b0;
    end else if (perm_en) begin
      perm_q <= 1'b1;
    end
  end

  // R9
  perm_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> $stable(lock_q));

endmodule

// File: rtl/flash_wp_judge.sv
module flash_wp_judge
  import flash_wp_pkg::*;
#(
  parameter int NBLK  = 16,
  parameter int NBOOT = 2,
  parameter int BW    = $clog2(NBLK)
) (
  input  op_kind_e        kind,
  input  logic [BW-1:0]   blk,
  input  logic [NBLK-1:0] lock_bits,
  input  logic            perm,
  input  logic            boot_n,
  input  logic            vlow,
  output wp_status_e      status,
  output logic            go,
  output logic [NBLK-1:0] mask
);

  logic [NBLK-1:0] pin_m;

  for (genvar i = 0; i < NBLK; i++) begin : g_pin
    if (i < NBOOT) begin : g_boot
      assign pin_m[i] = ~boot_n;
    end else begin : g_main
      assign pin_m[i] = 1'b0;
    end
  end

  always_comb begin
    status = ST_OK;
    go     = 1'b0;
    mask   = '0;
    if (vlow) begin
      status = (kind == OP_NONE) ? ST_OK : ST_SUPPLY;
    end else begin
      case (kind)
        OP_PROG, OP_ERASE: begin
          if (lock_bits[blk]) begin
            status = ST_LOCKED;
          end else if (pin_m[blk]) begin
            status = ST_BOOT;
          end else begin
            go        = 1'b1;
            mask[blk] = 1'b1;
          end
        end
        OP_CHIP: begin
          mask = ~(lock_bits | pin_m);
          go   = |mask;
          if (|lock_bits)  status = ST_LOCKED;
          else if (|pin_m) status = ST_BOOT;
        end
        OP_LSET, OP_LCLR: begin
          if (perm) status = ST_LOCKED;
          else      go     = 1'b1;
        end
        OP_PERM: go = 1'b1;
        default: go = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import flash_wp_pkg::*;
#(
  parameter int NBLK  = 16,
  parameter int NBOOT = 2,
  parameter int BW    = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            pd_n,
  input  logic            boot_n,
  input  logic            vlow,
  input  logic [7:0]      cmd,
  input  logic [BW-1:0]   blk,
  output logic            done,
  output logic [2:0]      status,
  output logic            op_go,
  output logic [2:0]      op_kind,
  output logic [BW-1:0]   op_blk,
  output logic [NBLK-1:0] op_mask,
  output logic [NBLK-1:0] lock_bits,
  output logic            perm_lock,
  output logic            seq_err
);

  logic            wr_raw, rst_hit, exec;
  op_kind_e        exec_kind, j_kind;
  wp_status_e      j_status;
  logic            j_go;
  logic [NBLK-1:0] j_mask, lock_q;
  logic            perm_q;
  logic            set_en, clr_en, perm_en, allow;

  logic            done_q, done_d, go_q, go_d;
  logic [2:0]      status_q, status_d, kind_q, kind_d;
  logic [BW-1:0]   blk_q;
  logic [NBLK-1:0] mask_q, mask_d;

  assign wr_raw  = ~ce_n & ~we_n;
  assign rst_hit = wr_raw & ~pd_n;

  flash_wp_cmd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_raw),
    .pd_n      (pd_n),
    .cmd       (cmd),
    .exec      (exec),
    .exec_kind (exec_kind),
    .seq_err   (seq_err)
  );

  assign j_kind = exec ? exec_kind : OP_NONE;

  flash_wp_judge #(.NBLK(NBLK), .NBOOT(NBOOT), .BW(BW)) u_judge (
    .kind      (j_kind),
    .blk       (blk),
    .lock_bits (lock_q),
    .perm      (perm_q),
    .boot_n    (boot_n),
    .vlow      (vlow),
    .status    (j_status),
    .go        (j_go),
    .mask      (j_mask)
  );

  assign allow   = exec & j_go;
  assign set_en  = allow & (j_kind == OP_LSET);
  assign clr_en  = allow & (j_kind == OP_LCLR);
  assign perm_en = allow & (j_kind == OP_PERM);

  flash_wp_lock_regs #(.NBLK(NBLK), .BW(BW)) u_locks (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .clr_en  (clr_en),
    .perm_en (perm_en),
    .idx     (blk),
    .lock_q  (lock_q),
    .perm_q  (perm_q)
  );

  always_comb begin
    done_d   = exec | rst_hit;
    go_d     = allow;
    status_d = rst_hit ? ST_RESET : j_status;
    kind_d   = j_kind;
    mask_d   = exec ? j_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      go_q   <= go_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      kind_q   <= '0;
      blk_q    <= '0;
      mask_q   <= '0;
    end else if (done_d) begin
      status_q <= status_d;
      kind_q   <= kind_d;
      blk_q    <= blk;
      mask_q   <= mask_d;
    end
  end

  assign done      = done_q;
  assign op_go     = go_q;
  assign status    = status_q;
  assign op_kind   = kind_q;
  assign op_blk    = blk_q;
  assign op_mask   = mask_q;
  assign lock_bits = lock_q;
  assign perm_lock = perm_q;

  // R1
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce_n || we_n) && pd_n) |=> !done_q);

  // R6
  supply_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> !$past(vlow));

  // R7
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && (kind_q == 3'd1 || kind_q == 3'd2)) |-> !lock_q[blk_q]);

  // R8
  boot_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && (kind_q == 3'd1 || kind_q == 3'd2) && !$past(boot_n)) |-> (blk_q >= BW'(NBOOT)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(pd_n) && pd_n) |=> !done_q);

  // R12
  pd_keeps_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> $stable(lock_q));

endmodule

// File: tb/flash_wp_gate_tb_top.sv
module flash_wp_gate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, ce_n, we_n, pd_n, boot_n, vlow;
  logic [7:0]  cmd;
  logic [3:0]  blk;
  logic        done, op_go, perm_lock, seq_err;
  logic [2:0]  status, op_kind;
  logic [3:0]  op_blk;
  logic [15:0] op_mask, lock_bits;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] lock_m;

  always #2 clk = ~clk;

  flash_wp_gate dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .pd_n(pd_n),
    .boot_n(boot_n), .vlow(vlow), .cmd(cmd), .blk(blk), .done(done),
    .status(status), .op_go(op_go), .op_kind(op_kind), .op_blk(op_blk),
    .op_mask(op_mask), .lock_bits(lock_bits), .perm_lock(perm_lock),
    .seq_err(seq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cyc(input logic [7:0] c, input logic [3:0] b, input logic cen, input logic wen);
    @(negedge clk);
    ce_n = cen; we_n = wen; cmd = c; blk = b;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic cmd2(input logic [7:0] c1, input logic [7:0] c2, input logic [3:0] b);
    wr_cyc(c1, b, 1'b0, 1'b0);
    wr_cyc(c2, b, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; pd_n = 1'b1;
    boot_n = 1'b1; vlow = 1'b0; cmd = '0; blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset locks", lock_bits, 0);
    chk("R12 reset perm", perm_lock, 0);
    chk("R2 reset done", done, 0);
    chk("R4 reset seq_err", seq_err, 0);

    // R1: gated setups never arm the decoder
    wr_cyc(8'h20, 4'd4, 1'b1, 1'b0);
    wr_cyc(8'hD0, 4'd4, 1'b0, 1'b0);
    chk("R1 ce_n high", done, 0);
    wr_cyc(8'h60, 4'd4, 1'b0, 1'b1);
    wr_cyc(8'h01, 4'd4, 1'b0, 1'b0);
    chk("R1 we_n high", done, 0);
    chk("R1 locks untouched", lock_bits, 0);
    // R3: a single confirm alone
    wr_cyc(8'hD0, 4'd2, 1'b0, 1'b0);
    chk("R3 lone confirm", done, 0);

    // load a lock pattern
    lock_m = 16'h5A96;
    for (int i = 0; i < 16; i++) begin
      if (lock_m[i]) begin
        cmd2(8'h60, 8'h01, 4'(i));
        chk("R3 lock set status", status, 0);
        chk("R3 lock set kind", op_kind, 4);
      end
    end
    chk("R12 lock pattern", lock_bits, lock_m);

    // sweep: block x pin x supply x kind
    for (int b = 0; b < 16; b++) begin
      for (int w = 0; w < 2; w++) begin
        for (int v = 0; v < 2; v++) begin
          for (int k = 0; k < 2; k++) begin
            int es;
            boot_n = w[0]; vlow = v[0];
            if (k == 0) cmd2(8'h40, 8'h77, 4'(b));
            else        cmd2(8'h20, 8'hD0, 4'(b));
            es = (v == 1) ? 3 : lock_m[b] ? 1 : (w == 0 && b < 2) ? 2 : 0;
            chk("R11 done pulse", done, 1);
            chk("R6/R7/R8 status", status, es);
            chk("R11 op_go", op_go, (es == 0));
            chk("R3 op_kind", op_kind, k + 1);
            chk("R11 op_mask", op_mask, (es == 0) ? (32'd1 << b) : 0);
          end
        end
      end
    end
    @(negedge clk);
    chk("R11 done one cycle", done, 0);

    // whole-array erase with the pattern
    for (int w = 0; w < 2; w++) begin
      for (int v = 0; v < 2; v++) begin
        logic [15:0] em;
        int es;
        boot_n = w[0]; vlow = v[0];
        cmd2(8'h30, 8'hD0, 4'd0);
        em = (v == 1) ? 16'h0 : ~(lock_m | ((w == 0) ? 16'h3 : 16'h0));
        es = (v == 1) ? 3 : 1;
        chk("R10 chip mask", op_mask, em);
        chk("R10 chip status", status, es);
        chk("R10 chip go", op_go, (em != 0));
      end
    end
    boot_n = 1'b1; vlow = 1'b0;

    // clear all locks
    for (int i = 0; i < 16; i++) begin
      if (lock_m[i]) begin
        cmd2(8'h60, 8'hD0, 4'(i));
        chk("R12 clear status", status, 0);
      end
    end
    lock_m = 16'h0;
    chk("R12 cleared", lock_bits, 0);
    boot_n = 1'b0;
    cmd2(8'h30, 8'hD0, 4'd0);
    chk("R10 pin-only mask", op_mask, 16'hFFFC);
    chk("R10 pin-only status", status, 2);
    boot_n = 1'b1;
    cmd2(8'h30, 8'hD0, 4'd0);
    chk("R10 open mask", op_mask, 16'hFFFF);
    chk("R10 open status", status, 0);

    // R4: bad confirm
    cmd2(8'h20, 8'h33, 4'd5);
    chk("R4 bad confirm no done", done, 0);
    chk("R4 seq_err set", seq_err, 1);
    wr_cyc(8'hD0, 4'd5, 1'b0, 1'b0);
    chk("R4 back in read", done, 0);
    wr_cyc(8'h50, 4'd0, 1'b0, 1'b0);
    chk("R4 seq_err clear", seq_err, 0);

    // R5 / R12: power-down
    cmd2(8'h60, 8'h01, 4'd5);
    lock_m = 16'h0020;
    pd_n = 1'b0;
    wr_cyc(8'h60, 4'd5, 1'b0, 1'b0);
    chk("R5 pd done", done, 1);
    chk("R5 pd status", status, 4);
    chk("R5 pd no go", op_go, 0);
    wr_cyc(8'hD0, 4'd5, 1'b0, 1'b0);
    chk("R12 pd keeps locks", lock_bits, lock_m);
    pd_n = 1'b1;
    wr_cyc(8'h20, 4'd3, 1'b0, 1'b0);
    @(negedge clk); pd_n = 1'b0;
    @(negedge clk); pd_n = 1'b1;
    wr_cyc(8'hD0, 4'd3, 1'b0, 1'b0);
    chk("R2 pd drops setup", done, 0);

    // R6 on lock command
    vlow = 1'b1;
    cmd2(8'h60, 8'h01, 4'd9);
    chk("R6 lock supply", status, 3);
    chk("R6 lock unchanged", lock_bits, lock_m);
    vlow = 1'b0;

    // R9: permanent lock
    cmd2(8'h60, 8'h2F, 4'd0);
    chk("R9 perm status", status, 0);
    chk("R9 perm set", perm_lock, 1);
    cmd2(8'h60, 8'h01, 4'd0);
    chk("R9 set refused", status, 1);
    cmd2(8'h60, 8'hD0, 4'd5);
    chk("R9 clear refused", status, 1);
    chk("R9 locks frozen", lock_bits, lock_m);
    cmd2(8'h60, 8'h2F, 4'd0);
    chk("R9 perm again", status, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule